// File: doc/BRIEF.md
# I2C Display Controller Slave Interface

This block is the two-wire serial front end of a display driver. It watches the clock and data lines, which it samples with the system clock, and recognises START, repeated START and STOP conditions. It answers one 7-bit address: the five fixed high bits `01110`, followed by the levels on two strap inputs, so that up to four drivers can share a bus. A driver that is not addressed stays silent until the next START or STOP.

In a write transfer, the byte after the address is a control byte. Its continue flag (bit 7) says whether a single data byte and then another control byte follow, or whether every remaining byte is data. Its target flag (bit 6) sends that data either to a command strobe port or to a display-RAM write port. Bits 5 to 0 carry no meaning. RAM writes use an internal data pointer. The pointer advances by one after each RAM byte and wraps at the RAM depth. The command decoder outside the block can load the pointer. In a read transfer, the block shifts out the byte presented on `rd_byte`, most significant bit first, for as long as the master acknowledges.

The controller is one state machine with these states: `ST_IDLE` (bus free), `ST_ADDR` (receiving the address), `ST_ADDR_ACK`, `ST_CTRL` (receiving a control byte), `ST_CTRL_ACK`, `ST_DATA` (receiving a data byte), `ST_DATA_ACK`, `ST_TX` (sending a byte), `ST_TX_ACK` (reading the master's acknowledge) and `ST_IGNORE` (not addressed, or read ended).

The transitions are as follows:
- STOP from any state goes to `ST_IDLE`.
- START from any state goes to `ST_ADDR`.
- A completed address goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_CTRL` for a write.
- `ST_CTRL` goes to `ST_CTRL_ACK`, which goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, which goes back to `ST_CTRL` when the continue flag was 1 and to `ST_DATA` when it was 0.
- `ST_TX` goes to `ST_TX_ACK`, which goes back to `ST_TX` on an acknowledge and to `ST_IGNORE` on a not-acknowledge.

All state changes caused by the serial clock happen on its synchronised falling edge. The only exceptions are START and STOP.

Top module: `disp_i2c_slave`

## Requirements
- R1: The block acknowledges, by driving `sda_oe` high through the ninth clock, an address byte whose bits 7..1 equal `01110` followed by `strap_a[1]`, `strap_a[0]`. Bit 0 of the address byte is the read flag (1 = read). While addressed, it also acknowledges every write byte.
- R2: After a non-matching address, the block drives no acknowledge and produces no command or RAM strobe until the next START or STOP.
- R3: In the first byte after a write address, bit 7 is the continue flag and bit 6 is the target flag (0 = command, 1 = RAM). Bits 5..0 have no effect.
- R4: With the continue flag at 0, every later byte of the transfer is data for the selected target.
- R5: With the continue flag at 1, exactly one data byte follows, and the byte after it is taken as a new control byte.
- R6: A command data byte gives a one-cycle `cmd_valid` pulse with the byte on `cmd_data`. A RAM data byte gives a one-cycle `ram_we` pulse with the byte on `ram_wdata`. The two never pulse in the same cycle.
- R7: Each RAM write goes to the current pointer, which then steps by one. The pointer wraps from RAM_DEPTH-1 to 0. A `ptr_load` pulse sets it to `ptr_value`, or to 0 when that value is not below RAM_DEPTH.
- R8: In a read, the block sends `rd_byte` MSB first after the address acknowledge. After a master acknowledge it sends the byte again. After a not-acknowledge it releases the data line until the next START or STOP.
- R9: A repeated START at any point, including in the middle of a byte, discards the partial byte and begins a new address phase.
- R10: `sda_oe` changes only while the serial clock is low.
- R11: After reset, `sda_oe`, `cmd_valid` and `ram_we` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_a | input | 2 | Strap levels forming address bits 1..0 |
| rd_byte | input | 8 | Status/temperature byte returned on reads |
| cmd_valid | output | 1 | One-cycle strobe for a command byte |
| cmd_data | output | 8 | Command byte, valid with `cmd_valid` |
| ram_we | output | 1 | One-cycle display RAM write strobe |
| ram_addr | output | PTR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ptr_load | input | 1 | Load the data pointer |
| ptr_value | input | PTR_W | Value for a pointer load |

## Verification
The hardest case to reach from the ports is a repeated START that arrives partway through a data byte, after the control byte has already fixed the target. The partial byte must then vanish without a strobe, and the new address phase must start cleanly. The bench drives this with a bit-level task: it sends half a byte and then issues a restart. Pointer wrap is reached by loading the pointer two slots below the RAM depth before writing several RAM bytes. Randomly built transfers then mix continue and target flags, junk low bits and mismatched straps.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

    // Fixed upper part of the 7-bit bus address
    localparam logic [4:0] ADDR_HI = 5'b01110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        logic cont;     // another control byte after one data byte
        logic sel_ram;  // data goes to display RAM when set
    } ctrl_t;

endpackage

// File: rtl/disp_i2c_cond.sv
// Synchroniser and bus condition detector
module disp_i2c_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [STAGES-1:0] chain [NLINES];
    logic [NLINES-1:0] synced;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= '1;
            end else begin
                chain[g] <= {chain[g][STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[g][STAGES-1];
    end

    assign scl_now = synced[1];
    assign sda_s   = synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/disp_i2c_shreg.sv
// Receive and transmit shift registers
module disp_i2c_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         rx_bit,
    input  logic         tx_load,
    input  logic [W-1:0] tx_val,
    input  logic         tx_shift,
    output logic [W-1:0] rx_word,
    output logic         tx_msb
);

    logic [W-1:0] rx_q;
    logic [W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rx_en) begin
            rx_q <= {rx_q[W-2:0], rx_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
        end else if (tx_load) begin
            tx_q <= tx_val;
        end else if (tx_shift) begin
            tx_q <= {tx_q[W-2:0], 1'b1};
        end
    end

    assign rx_word = rx_q;
    assign tx_msb  = tx_q[W-1];

endmodule

// File: rtl/disp_i2c_ptr.sv
// Display RAM data pointer with wrap and external load
module disp_i2c_ptr #(
    parameter int DEPTH = 40,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          step,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= (int'(load_val) >= DEPTH) ? '0 : load_val;
        end else if (step) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave
    import disp_i2c_pkg::*;
#(
    parameter int RAM_DEPTH   = 40,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       strap_a,
    input  logic [7:0]       rd_byte,
    output logic             cmd_valid,
    output logic [7:0]       cmd_data,
    output logic             ram_we,
    output logic [PTR_W-1:0] ram_addr,
    output logic [7:0]       ram_wdata,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_value
);

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    // Condition detector outputs
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    // State and context
    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [CNT_W-1:0] bitcnt_q;
    logic             rw_q;
    ctrl_t            ctrl_q;
    logic             mack_q;

    // Datapath links
    logic [7:0]       rx_word;
    logic             tx_msb;
    logic             rx_en;
    logic             tx_load;
    logic             tx_shift;
    logic             byte_done;
    logic             addr_hit;
    logic             data_evt;
    logic             ptr_step;
    logic [PTR_W-1:0] ptr_cur;

    disp_i2c_cond #(
        .STAGES (SYNC_STAGES)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    disp_i2c_shreg #(
        .W (BYTE_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .rx_bit   (sda_s),
        .tx_load  (tx_load),
        .tx_val   (rd_byte),
        .tx_shift (tx_shift),
        .rx_word  (rx_word),
        .tx_msb   (tx_msb)
    );

    disp_i2c_ptr #(
        .DEPTH (RAM_DEPTH),
        .PW    (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_value),
        .step     (ptr_step),
        .ptr      (ptr_cur)
    );

    // Event decode
    assign byte_done = scl_fall && (bitcnt_q == LAST_BIT);
    assign rx_en     = scl_rise && ((state_q == ST_ADDR) || (state_q == ST_CTRL)
                                    || (state_q == ST_DATA));
    assign addr_hit  = (rx_word[7:1] == {ADDR_HI, strap_a});
    assign tx_load   = scl_fall && (((state_q == ST_ADDR_ACK) && rw_q)
                                    || ((state_q == ST_TX_ACK) && mack_q));
    assign tx_shift  = scl_fall && (state_q == ST_TX) && (bitcnt_q != LAST_BIT);
    assign data_evt  = (state_q == ST_DATA) && byte_done;
    assign ptr_step  = data_evt && ctrl_q.sel_ram;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        state_d = rw_q ? ST_TX : ST_CTRL;
                    end
                end
                ST_CTRL: begin
                    if (byte_done) begin
                        state_d = ST_CTRL_ACK;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        state_d = ST_DATA_ACK;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ctrl_q.cont ? ST_CTRL : ST_DATA;
                    end
                end
                ST_TX: begin
                    if (byte_done) begin
                        state_d = ST_TX_ACK;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_fall) begin
                        state_d = mack_q ? ST_TX : ST_IGNORE;
                    end
                end
                ST_IGNORE: begin
                    state_d = ST_IGNORE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            rw_q     <= 1'b0;
            ctrl_q   <= '0;
            mack_q   <= 1'b0;
        end else begin
            state_q <= state_d;

            if (start_det || (state_d != state_q)) begin
                bitcnt_q <= '0;
            end else if (scl_rise && (bitcnt_q != LAST_BIT)) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end

            if ((state_q == ST_ADDR) && byte_done) begin
                rw_q <= rx_word[0];
            end

            if ((state_q == ST_CTRL) && byte_done) begin
                ctrl_q.cont    <= rx_word[7];
                ctrl_q.sel_ram <= rx_word[6];
            end

            if ((state_q == ST_TX_ACK) && scl_rise) begin
                mack_q <= ~sda_s;
            end
        end
    end

    // Output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            cmd_valid <= data_evt && !ctrl_q.sel_ram;
            ram_we    <= data_evt && ctrl_q.sel_ram;
            if (data_evt && !ctrl_q.sel_ram) begin
                cmd_data <= rx_word;
            end
            if (data_evt && ctrl_q.sel_ram) begin
                ram_addr  <= ptr_cur;
                ram_wdata <= rx_word;
            end
        end
    end

    // Data line driver
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK,
            ST_CTRL_ACK,
            ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:       sda_oe = ~tx_msb;
            default:     sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/disp_i2c_chk.sv
module disp_i2c_chk
    import disp_i2c_pkg::*;
#(
    parameter int RAM_DEPTH = 40,
    parameter int PTR_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             cmd_valid,
    input logic             ram_we,
    input logic [PTR_W-1:0] ram_addr,
    input logic             ptr_load,
    input logic [PTR_W-1:0] cur_ptr,
    input bus_state_e       state
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);

    // R10: data line only moves while the clock is low
    assert_sda_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R6: the two strobes are exclusive
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !ram_we);

    // R6: command strobe lasts one cycle
    assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: RAM strobe lasts one cycle
    assert_ram_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R7: pointer has moved one step past the written address
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !$past(ptr_load)) |->
            (cur_ptr == ((ram_addr == LAST) ? '0 : ram_addr + 1'b1)));

    // R2: no acknowledge while ignoring the bus
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R2: no strobes while ignoring the bus
    assert_ignore_nostrobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IGNORE) && ($past(state) == ST_IGNORE)) |-> (!cmd_valid && !ram_we));

endmodule

bind disp_i2c_slave disp_i2c_chk #(
    .RAM_DEPTH (RAM_DEPTH),
    .PTR_W     (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ptr_load  (ptr_load),
    .cur_ptr   (ptr_cur),
    .state     (state_q)
);

// File: tb/sim_disp_i2c_slave.sv
module sim_disp_i2c_slave;

    localparam int DEPTH = 40;
    localparam int PW    = 6;
    localparam int Q     = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scl_m;
    logic          sda_m;
    logic          sda_bus;
    logic          sda_oe;
    logic [1:0]    strap;
    logic [7:0]    rd_val;
    logic          cmd_valid;
    logic [7:0]    cmd_data;
    logic          ram_we;
    logic [PW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          ptr_load;
    logic [PW-1:0] ptr_value;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;

    logic [7:0]    act_cmd[$];
    logic [7:0]    exp_cmd[$];
    logic [PW-1:0] act_ra[$];
    logic [PW-1:0] exp_ra[$];
    logic [7:0]    act_rd[$];
    logic [7:0]    exp_rd[$];

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    disp_i2c_slave #(.RAM_DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .strap_a   (strap),
        .rd_byte   (rd_val),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ptr_load  (ptr_load),
        .ptr_value (ptr_value)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) act_cmd.push_back(cmd_data);
            if (ram_we) begin
                act_ra.push_back(ram_addr);
                act_rd.push_back(ram_wdata);
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = (sda_bus == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            scl_m = 1'b0; wq();
        end
        put_bit(~mack);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(logic [1:0] a, bit rd);
        return {5'b01110, a, rd};
    endfunction

    task automatic expect_data(logic rs, logic [7:0] d);
        if (rs) begin
            exp_ra.push_back(PW'(exp_ptr));
            exp_rd.push_back(d);
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end else begin
            exp_cmd.push_back(d);
        end
    endtask

    task automatic compare_logs(string req);
        repeat (20) @(negedge clk);
        check(act_cmd.size() == exp_cmd.size(), req, "command count", act_cmd.size(), exp_cmd.size());
        check(act_ra.size() == exp_ra.size(), req, "RAM write count", act_ra.size(), exp_ra.size());
        if (act_cmd.size() == exp_cmd.size())
            for (int i = 0; i < act_cmd.size(); i++)
                check(act_cmd[i] == exp_cmd[i], req, "command byte", act_cmd[i], exp_cmd[i]);
        if (act_ra.size() == exp_ra.size())
            for (int i = 0; i < act_ra.size(); i++) begin
                check(act_ra[i] == exp_ra[i], req, "RAM address", act_ra[i], exp_ra[i]);
                check(act_rd[i] == exp_rd[i], req, "RAM data", act_rd[i], exp_rd[i]);
            end
        act_cmd.delete(); exp_cmd.delete();
        act_ra.delete();  exp_ra.delete();
        act_rd.delete();  exp_rd.delete();
    endtask

    // Control byte with random junk in bits 5..0 (R3)
    task automatic send_ctrl(logic co, logic rs, bit matched, string req);
        bit ack;
        logic [5:0] junk;
        junk = 6'($urandom);
        put_byte({co, rs, junk}, ack);
        check(ack == matched, req, "control ack", ack, matched);
    endtask

    task automatic send_data(logic rs, logic [7:0] d, bit matched, string req);
        bit ack;
        put_byte(d, ack);
        check(ack == matched, req, "data ack", ack, matched);
        if (matched) expect_data(rs, d);
    endtask

    task automatic load_ptr(int v);
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_value = PW'(v);
        @(negedge clk);
        ptr_load = 1'b0;
        exp_ptr = (v >= DEPTH) ? 0 : v;
    endtask

    task automatic rand_write(bit matched);
        bit ack;
        logic [1:0] a;
        int groups;
        a = matched ? strap : (strap ^ 2'(1 + $urandom % 3));
        bus_start();
        put_byte(addr_byte(a, 1'b0), ack);
        check(ack == matched, matched ? "R1" : "R2", "address ack", ack, matched);
        groups = 1 + $urandom % 3;
        for (int g = 0; g < groups; g++) begin
            logic co;
            logic rs;
            co = (g == groups - 1) ? 1'b0 : 1'b1;
            rs = 1'($urandom);
            send_ctrl(co, rs, matched, "R3");
            if (co) begin
                send_data(rs, 8'($urandom), matched, "R5");
            end else begin
                int n;
                n = 1 + $urandom % 3;
                for (int k = 0; k < n; k++) send_data(rs, 8'($urandom), matched, "R4");
            end
        end
        bus_stop();
        compare_logs(matched ? "R6" : "R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst_n = 1'b0;
        scl_m = 1'b1;
        sda_m = 1'b1;
        strap = 2'b10;
        rd_val = 8'hC6;
        ptr_load = 1'b0;
        ptr_value = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        check(sda_oe == 1'b0, "R11", "sda_oe after reset", sda_oe, 0);
        check(cmd_valid == 1'b0 && ram_we == 1'b0, "R11", "strobes after reset",
              {cmd_valid, ram_we}, 0);

        // R4 / R6: continue=0, commands only
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        check(ack, "R1", "address ack", ack, 1);
        send_ctrl(1'b0, 1'b0, 1'b1, "R4");
        send_data(1'b0, 8'h3A, 1'b1, "R4");
        send_data(1'b0, 8'hC5, 1'b1, "R4");
        send_data(1'b0, 8'h80, 1'b1, "R4");
        bus_stop();
        compare_logs("R4");

        // R5 / R3: alternating control bytes; R11 pointer starts at 0
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        send_ctrl(1'b1, 1'b1, 1'b1, "R5");
        send_data(1'b1, 8'h11, 1'b1, "R5");
        send_ctrl(1'b1, 1'b0, 1'b1, "R5");
        send_data(1'b0, 8'hE2, 1'b1, "R5");
        send_ctrl(1'b0, 1'b1, 1'b1, "R3");
        send_data(1'b1, 8'h33, 1'b1, "R3");
        send_data(1'b1, 8'h44, 1'b1, "R3");
        bus_stop();
        compare_logs("R5");

        // R2: wrong strap levels, every byte ignored
        bus_start();
        put_byte(addr_byte(~strap, 1'b0), ack);
        check(!ack, "R2", "address ack on mismatch", ack, 0);
        send_ctrl(1'b0, 1'b1, 1'b0, "R2");
        send_data(1'b1, 8'h99, 1'b0, "R2");
        bus_stop();
        compare_logs("R2");

        // R7: pointer wrap and load
        load_ptr(DEPTH - 2);
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        send_ctrl(1'b0, 1'b1, 1'b1, "R7");
        for (int k = 0; k < 4; k++) send_data(1'b1, 8'(8'hA0 + k), 1'b1, "R7");
        bus_stop();
        check(exp_ra.size() == 4 && exp_ra[2] == '0, "R7", "model wrap", exp_ra[2], 0);
        compare_logs("R7");
        load_ptr(DEPTH + 3);
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        send_ctrl(1'b0, 1'b1, 1'b1, "R7");
        send_data(1'b1, 8'h5C, 1'b1, "R7");
        bus_stop();
        compare_logs("R7");

        // R8: read with ack then nack
        bus_start();
        put_byte(addr_byte(strap, 1'b1), ack);
        check(ack, "R8", "read address ack", ack, 1);
        get_byte(b, 1'b1);
        check(b == rd_val, "R8", "first read byte", b, rd_val);
        get_byte(b, 1'b0);
        check(b == rd_val, "R8", "second read byte", b, rd_val);
        repeat (2 * Q) @(negedge clk);
        check(sda_oe == 1'b0, "R8", "line released after nack", sda_oe, 0);
        bus_stop();

        // R9: repeated START mid-byte, then read, then write
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        send_ctrl(1'b0, 1'b0, 1'b1, "R9");
        send_data(1'b0, 8'h5A, 1'b1, "R9");
        for (int k = 0; k < 4; k++) put_bit(1'b1);
        bus_start();
        put_byte(addr_byte(strap, 1'b1), ack);
        check(ack, "R9", "address ack after restart", ack, 1);
        rd_val = 8'h27;
        get_byte(b, 1'b0);
        bus_start();
        put_byte(addr_byte(strap, 1'b0), ack);
        check(ack, "R9", "write address after restart", ack, 1);
        send_ctrl(1'b0, 1'b1, 1'b1, "R9");
        send_data(1'b1, 8'h6B, 1'b1, "R9");
        bus_stop();
        compare_logs("R9");

        // Random mixture
        for (int t = 0; t < 18; t++) begin
            strap = 2'($urandom);
            rand_write(($urandom % 4) != 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule